// File: doc/BRIEF.md
# Converter Serial Port Slave Model

This block is a synthesizable stand-in for the digital side of a successive-approximation converter's serial port. It is placed on the device side of a test setup so that a host controller can be exercised against it without any analog parts. The host drives a conversion-start line, a serial clock and a serial data input; the block answers on a serial data output with a separate output-enable, so a pad wrapper can turn it into a three-state pin.

A rising conversion-start edge begins a conversion that lasts a fixed number of system clock cycles. At its end the block latches the value on a stimulus input as the conversion result. Once the host pulls the start line low after that, the result is shifted out most significant bit first, advanced on falling serial clock edges, optionally followed by the configuration word that governed that conversion. At the same time the host can write a new 14-bit configuration word on rising serial clock edges. A fully written word is committed when the start line rises and governs the conversion after the one that this same edge starts.

All host signals are taken as synchronous to the system clock. They pass one register stage before their edges are detected, and the outputs are registered.

Top module: `adc_port_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sdo_oe` and `sdo` are 0 until a conversion has completed and the start line has fallen.
- R2: A rising edge on `cnv` drives `sdo_oe` to 0 within two clock cycles, whatever the frame was doing.
- R3: A conversion started by a `cnv` rising edge lasts `CONV_CYCLES` clock cycles; further `cnv` edges during it neither stop nor restart it, and `sample_in` is latched as the result when it ends.
- R4: A `cnv` falling edge while no conversion runs sets `sdo_oe` and puts the result MSB on `sdo` without any serial clock edge; a falling edge during a conversion enables nothing.
- R5: Each falling `sck` edge while `sdo_oe` is high advances `sdo` to the next result bit, MSB first.
- R6: With the readback-enable bit (bit 0 of the configuration word, 1 = echo on) clear in the configuration tied to the result, `sdo_oe` drops on the 16th falling `sck` edge.
- R7: With that bit set, the 14-bit configuration word tied to the result follows the result LSB, MSB first, and `sdo_oe` drops on the 30th falling `sck` edge.
- R8: `sdo_oe` is only high while `cnv` is low; a `cnv` rising edge ends the output early, before the full bit count.
- R9: While `cnv` is low, `din` is sampled MSB first on the first 14 rising `sck` edges; later rising edges in the same frame are ignored, and the word is committed at the next `cnv` rising edge.
- R10: A frame with fewer than 14 rising `sck` edges commits nothing; the previous configuration stays in force.
- R11: A word committed at a `cnv` rising edge governs the conversion started by the next `cnv` rising edge, not the one started by the commit edge.
- R12: Each completed conversion replaces the stored result; a result that was never read is lost.
- R13: After reset the configuration is `CFG_DEFAULT`, whose readback-enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Conversion start and frame select from the host |
| sck | input | 1 | Serial clock from the host |
| din | input | 1 | Serial configuration data from the host |
| sample_in | input | RES_W | Stimulus value latched as the result at the end of each conversion |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | High while `sdo` is driven; low means high impedance |

## Verification
The bench builds the block with `CONV_CYCLES` set to 20 and the default widths of 16 result bits and 14 configuration bits, so a full 30-bit echo frame and several back-to-back conversions fit in a few hundred cycles. The short conversion makes it cheap to toggle `cnv` inside a conversion and to change `sample_in` on either side of its end, which separates a correct fixed-length conversion from a restarted one. A reference model in the bench tracks the two configuration stages, so every frame's bit count and echoed word check the commit pipeline, the discarded partial word and the ignored extra rising edges.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  // Bit of the configuration word that enables the echo after the result.
  localparam int RB_BIT = 0;

  function automatic int ctr_width(input int max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/adc_input_stage.sv
module adc_input_stage (
  input  logic clk,
  input  logic rst,
  input  logic cnv,
  input  logic sck,
  input  logic din,
  output logic cnv_low,
  output logic cnv_rise,
  output logic cnv_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic din_s
);
  logic cnv_q, cnv_d, sck_q, sck_d, din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_q <= 1'b0;
      cnv_d <= 1'b0;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      din_q <= 1'b0;
    end else begin
      cnv_q <= cnv;
      cnv_d <= cnv_q;
      sck_q <= sck;
      sck_d <= sck_q;
      din_q <= din;
    end
  end

  assign cnv_low  = ~cnv_q;
  assign cnv_rise = cnv_q & ~cnv_d;
  assign cnv_fall = ~cnv_q & cnv_d;
  assign sck_rise = sck_q & ~sck_d;
  assign sck_fall = ~sck_q & sck_d;
  assign din_s    = din_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 60,
  parameter int RES_W       = 16,
  parameter int CFG_W       = 14,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0,
  localparam int CW = adc_port_pkg::ctr_width(CONV_CYCLES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [RES_W-1:0] sample_in,
  input  logic [CFG_W-1:0] cfg_new,
  output logic             busy,
  output logic [CW-1:0]    cnt,
  output logic [RES_W-1:0] result,
  output logic [CFG_W-1:0] res_cfg
);
  // Configuration in force for the conversion that is running.
  logic [CFG_W-1:0] cfg_conv;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      result   <= '0;
      cfg_conv <= CFG_DEFAULT;
      res_cfg  <= CFG_DEFAULT;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt      <= CW'(CONV_CYCLES - 1);
      cfg_conv <= cfg_new;
    end else if (busy) begin
      if (cnt == '0) begin
        busy    <= 1'b0;
        result  <= sample_in;
        res_cfg <= cfg_conv;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_cfg_capture.sv
module adc_cfg_capture #(
  parameter int CFG_W = 14,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0,
  localparam int NW = adc_port_pkg::ctr_width(CFG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnv_low,
  input  logic             cnv_rise,
  input  logic             cnv_fall,
  input  logic             sck_rise,
  input  logic             din,
  output logic [CFG_W-1:0] cfg_new
);
  logic [CFG_W-1:0] sr;
  logic [NW-1:0]    nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      nbits   <= '0;
      cfg_new <= CFG_DEFAULT;
    end else if (cnv_rise) begin
      if (nbits == NW'(CFG_W)) cfg_new <= sr;
      nbits <= '0;
    end else if (cnv_fall) begin
      nbits <= '0;
    end else if (cnv_low && sck_rise && nbits != NW'(CFG_W)) begin
      sr    <= {sr[CFG_W-2:0], din};
      nbits <= nbits + NW'(1);
    end
  end
endmodule

// File: rtl/adc_sdo_shifter.sv
module adc_sdo_shifter #(
  parameter int RES_W  = 16,
  parameter int CFG_W  = 14,
  parameter int RB_BIT = 0,
  localparam int TOT = RES_W + CFG_W,
  localparam int CW  = adc_port_pkg::ctr_width(TOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             stop,
  input  logic             sck_fall,
  input  logic [RES_W-1:0] result,
  input  logic [CFG_W-1:0] res_cfg,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [CW-1:0]    fall_cnt
);
  logic [TOT-1:0] sr;
  logic [CW-1:0]  limit;
  logic [CW-1:0]  nxt;

  always_comb nxt = fall_cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      fall_cnt <= '0;
      limit    <= CW'(RES_W);
    end else if (stop) begin
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (load) begin
      sr       <= {result, res_cfg};
      sdo      <= result[RES_W-1];
      sdo_oe   <= 1'b1;
      fall_cnt <= '0;
      limit    <= res_cfg[RB_BIT] ? CW'(TOT) : CW'(RES_W);
    end else if (sdo_oe && sck_fall) begin
      fall_cnt <= nxt;
      if (nxt == limit) begin
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
      end else begin
        sr  <= {sr[TOT-2:0], 1'b0};
        sdo <= sr[TOT-2];
      end
    end
  end
endmodule

// File: rtl/adc_port_slave.sv
module adc_port_slave #(
  parameter int CONV_CYCLES = 60,
  parameter int RES_W       = 16,
  parameter int CFG_W       = 14,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 14'h3C48,
  localparam int TOT = RES_W + CFG_W,
  localparam int CCW = adc_port_pkg::ctr_width(CONV_CYCLES - 1),
  localparam int FCW = adc_port_pkg::ctr_width(TOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnv,
  input  logic             sck,
  input  logic             din,
  input  logic [RES_W-1:0] sample_in,
  output logic             sdo,
  output logic             sdo_oe
);
  logic             cnv_low, cnv_rise, cnv_fall, sck_rise, sck_fall, din_s;
  logic             conv_busy;
  logic [CCW-1:0]   conv_cnt;
  logic [RES_W-1:0] result;
  logic [CFG_W-1:0] res_cfg, cfg_new;
  logic [FCW-1:0]   fall_cnt;

  adc_input_stage u_in (
    .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .din(din),
    .cnv_low(cnv_low), .cnv_rise(cnv_rise), .cnv_fall(cnv_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din_s(din_s)
  );

  adc_cfg_capture #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_cfg (
    .clk(clk), .rst(rst), .cnv_low(cnv_low), .cnv_rise(cnv_rise),
    .cnv_fall(cnv_fall), .sck_rise(sck_rise), .din(din_s), .cfg_new(cfg_new)
  );

  adc_conv_timer #(
    .CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W), .CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)
  ) u_conv (
    .clk(clk), .rst(rst), .start(cnv_rise), .sample_in(sample_in),
    .cfg_new(cfg_new), .busy(conv_busy), .cnt(conv_cnt),
    .result(result), .res_cfg(res_cfg)
  );

  adc_sdo_shifter #(.RES_W(RES_W), .CFG_W(CFG_W), .RB_BIT(adc_port_pkg::RB_BIT)) u_sdo (
    .clk(clk), .rst(rst), .load(cnv_fall && !conv_busy), .stop(cnv_rise),
    .sck_fall(sck_fall), .result(result), .res_cfg(res_cfg),
    .sdo(sdo), .sdo_oe(sdo_oe), .fall_cnt(fall_cnt)
  );
endmodule

// File: rtl/adc_port_slave_chk.sv
module adc_port_slave_chk #(
  parameter int CCW = 6,
  parameter int FCW = 5,
  parameter int TOT = 30
) (
  input logic           clk,
  input logic           rst,
  input logic           cnv,
  input logic           sdo_oe,
  input logic           busy,
  input logic [CCW-1:0] conv_cnt,
  input logic [FCW-1:0] fall_cnt
);
  AST_RST_HIZ: assert property (@(posedge clk) rst |=> !sdo_oe); // R1

  AST_CNV_RISE_HIZ: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv) |=> ##1 !sdo_oe); // R2

  AST_CONV_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_cnt != '0) |=> busy); // R3

  AST_NO_OE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !$past(busy)); // R4

  AST_OE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> fall_cnt < FCW'(TOT)); // R7

  AST_OE_NEEDS_CNV_LOW: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !$past(cnv, 2)); // R8
endmodule

bind adc_port_slave adc_port_slave_chk #(.CCW(CCW), .FCW(FCW), .TOT(TOT)) u_chk (
  .clk(clk), .rst(rst), .cnv(cnv), .sdo_oe(sdo_oe),
  .busy(conv_busy), .conv_cnt(conv_cnt), .fall_cnt(fall_cnt)
);

// File: tb/test_adc_port_slave.sv
module test_adc_port_slave;
  localparam int CONV = 20;
  localparam logic [13:0] CDEF = 14'h3C48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv = 1'b0, sck = 1'b0, din = 1'b0;
  logic [15:0] sample_in = '0;
  logic sdo, sdo_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference model of the configuration pipeline and result.
  logic [13:0] m_new = CDEF, m_conv = CDEF, m_rescfg = CDEF, pend = '0;
  logic [15:0] m_res = '0;
  bit pend_ok = 1'b0;

  always #5 clk = ~clk;

  adc_port_slave #(.CONV_CYCLES(CONV), .CFG_DEFAULT(CDEF)) i_adc_port_slave (
    .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .din(din),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Start a conversion with a fixed stimulus value and let it complete.
  task automatic convert(input logic [15:0] s);
    sample_in = s;
    cnv = 1'b1;
    m_conv = m_new;
    if (pend_ok) m_new = pend;
    pend_ok = 1'b0;
    tick(CONV + 6);
    m_res = s;
    m_rescfg = m_conv;
  endtask

  // One frame with cnv low: nclk serial clocks, writing word, reading sdo.
  task automatic frame(input logic [13:0] word, input int nclk, input string req,
                       output int nb);
    logic [29:0] got, exp;
    int exp_n, bad;
    got = '0; nb = 0; bad = 0;
    cnv = 1'b0;
    tick(4);
    for (int k = 0; k < nclk; k++) begin
      if (sdo_oe) begin got[29-nb] = sdo; nb++; end
      din = (k < 14) ? word[13-k] : 1'b1;
      sck = 1'b1; tick(3);
      sck = 1'b0; tick(3);
    end
    din = 1'b0;
    if (nclk >= 14) begin pend = word; pend_ok = 1'b1; end
    exp = {m_res, m_rescfg};
    exp_n = m_rescfg[0] ? 30 : 16;
    if (exp_n > nclk) exp_n = nclk;
    for (int i = 0; i < nb; i++) if (got[29-i] != exp[29-i]) bad++;
    chk(nb == exp_n, {req, " bit count"}, nb, exp_n);
    chk(bad == 0, {req, " data"}, int'(got[29 -: 16]), int'(exp[29 -: 16]));
    if (nb > 16)
      chk(got[13:0] == exp[13:0], {req, " echoed config"}, int'(got[13:0]), int'(exp[13:0]));
  endtask

  task automatic t_reset;
    tick(2);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 sdo_oe in reset", int'(sdo_oe), 0);
    rst = 1'b0;
    tick(5);
    chk(sdo_oe == 1'b0, "R1 sdo_oe after reset", int'(sdo_oe), 0);
  endtask

  task automatic t_first_read;
    int nb;
    convert(16'hA5C3);
    cnv = 1'b0; tick(4);
    chk(sdo_oe == 1'b1, "R4 enable on cnv fall", int'(sdo_oe), 1);
    chk(sdo == 1'b1, "R4 MSB without sck", int'(sdo), 1);
    cnv = 1'b1; tick(3); // short frame, no clocks, nothing committed
    // R13 R5 R6: default config has echo off, 16 bits
    m_conv = m_new; tick(CONV + 6); m_rescfg = m_conv; m_res = 16'hA5C3;
    frame(14'h2A55, 32, "R6 R13 R5 R9 default frame", nb);
  endtask

  task automatic t_pipeline;
    int nb;
    convert(16'h1234);
    frame(14'h1C33, 32, "R11 first conversion after commit", nb);
    convert(16'hFEDC);
    frame(14'h0F0E, 32, "R7 R9 echo of committed word", nb);
  endtask

  task automatic t_early_end;
    int nb;
    convert(16'h8001);
    frame(14'h3FFF, 10, "R8 partial frame", nb);
    chk(sdo_oe == 1'b1, "R8 still driving before cnv rise", int'(sdo_oe), 1);
    cnv = 1'b1; tick(3);
    chk(sdo_oe == 1'b0, "R2 R8 cnv rise ends output", int'(sdo_oe), 0);
    pend_ok = 1'b0; // R10 partial word must not commit
    m_conv = m_new; tick(CONV + 6); m_res = 16'h8001; m_rescfg = m_conv;
    sample_in = 16'h5A5A;
    frame(14'h0666, 32, "R10 config after partial", nb);
    convert(16'h7E81);
    frame(14'h0001, 32, "R10 partial word not applied", nb);
  endtask

  task automatic t_conv_ignores_cnv;
    int nb;
    sample_in = 16'hC0DE;
    cnv = 1'b1;
    m_conv = m_new;
    if (pend_ok) m_new = pend;
    pend_ok = 1'b0;
    tick(5);
    cnv = 1'b0; tick(5);
    chk(sdo_oe == 1'b0, "R4 no enable during conversion", int'(sdo_oe), 0);
    cnv = 1'b1; tick(16);
    sample_in = 16'h0BAD;
    tick(20);
    m_res = 16'hC0DE; m_rescfg = m_conv;
    frame(14'h0000, 32, "R3 fixed length conversion", nb);
  endtask

  task automatic t_data_loss;
    int nb;
    convert(16'h1111);
    cnv = 1'b0; tick(3); // frame with no clocks: result unread
    convert(16'h2222);
    frame(14'h0000, 32, "R12 unread result replaced", nb);
  endtask

  initial begin
    t_reset;
    t_first_read;
    t_pipeline;
    t_early_end;
    t_conv_ignores_cnv;
    t_data_loss;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule